// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block produces the active-high interrupt line of each UART channel. Each channel's line comes from the channel's transmit and receive status. A channel works in one of two ways, chosen by its FIFO-enable bit. With the FIFO disabled, the block follows a single-byte holding register. With the FIFO enabled, it compares the FIFO occupancy counts against programmable trigger levels.

A second mode bit, automatic RS-485 operation, changes when the transmit side may raise a request. It holds the request back until the whole transmitter is empty, which includes the shift register. The transmit and receive requests each pass through their own enable bit. The two results are ORed and then registered on the system clock. All channels are built from the same logic, and each channel has its own independent output.

Top module: `uart_irq_pin`

## Requirements
- R1: After a clock edge with `rst` high, every bit of `irq` is 0, whatever the other inputs are.
- R2: With the FIFO disabled and RS-485 mode off, the transmit request is high exactly when `thr_full` is 0.
- R3: With the FIFO disabled and RS-485 mode on, the transmit request is high only when `thr_full` is 0 and `tsr_idle` is 1.
- R4: With the FIFO enabled and RS-485 mode off, the transmit request is high when the transmit count is below the transmit trigger or the count is 0. It is low when a nonzero count is equal to or above the trigger.
- R5: With the FIFO enabled and RS-485 mode on, the transmit request is high when the count is below the trigger, or when the count is 0 and `tsr_idle` is 1. In every other case it is low. A trigger of 0 with a busy shift register therefore keeps the request low.
- R6: With the FIFO disabled, the receive request is high exactly when the receive count is nonzero, meaning a byte is held.
- R7: With the FIFO enabled, the receive request is high when the receive count is equal to or above the receive trigger and the count is nonzero. An empty FIFO never requests, even with a trigger of 0.
- R8: Each request counts only when its enable bit is 1. A channel's `irq` bit is the OR of its enabled transmit and receive requests.
- R9: `irq` is registered. It reflects the inputs sampled at the previous rising clock edge and does not change between edges.
- R10: Channels are independent. Channel c uses only bit c of each control input and the c-th CW-bit field of each count and trigger bus, where field c occupies bits [c*CW +: CW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | NCH | Per channel: 1 selects trigger-level mode, 0 selects single-byte mode |
| rs485_auto | input | NCH | Per channel: 1 makes transmit requests wait for the transmitter to drain |
| tx_ien | input | NCH | Per channel transmit request enable |
| rx_ien | input | NCH | Per channel receive request enable |
| thr_full | input | NCH | Per channel: transmit holding register holds a byte |
| tsr_idle | input | NCH | Per channel: transmit shift register is empty |
| tx_count | input | NCH*CW | Transmit FIFO occupancy, one CW-bit field per channel |
| tx_trig | input | NCH*CW | Transmit trigger level, one field per channel |
| rx_count | input | NCH*CW | Receive FIFO occupancy (in single-byte mode, nonzero means a byte is held) |
| rx_trig | input | NCH*CW | Receive trigger level, one field per channel |
| irq | output | NCH | Registered active-high interrupt line per channel |

## Verification
Every result arrives exactly one rising edge after the inputs that cause it, because the only register on the path is the output flop. The bench applies each input pattern at a falling edge and compares `irq` at the next falling edge, half a period after the rising edge that captured the pattern. One directed test samples just before that rising edge to confirm the old value is still held, and then samples after it to see the new one. The reset test raises `rst` with active requests on the inputs and checks the output one edge later.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Transmit selection: FIFO enable and drain-wait together pick one of four rules.
    typedef enum logic [1:0] {
        TXM_HOLD       = 2'd0,
        TXM_HOLD_DRAIN = 2'd1,
        TXM_FIFO       = 2'd2,
        TXM_FIFO_DRAIN = 2'd3
    } tx_mode_e;

    typedef enum logic {
        RXM_HOLD = 1'b0,
        RXM_FIFO = 1'b1
    } rx_mode_e;

    // Per-channel control bundle.
    typedef struct packed {
        logic fifo_en;
        logic drain_wait;
        logic tx_en;
        logic rx_en;
    } ch_ctrl_t;

    // Transmitter status that does not depend on count width.
    typedef struct packed {
        logic hold_full;
        logic shift_idle;
    } tx_flags_t;

    function automatic tx_mode_e pick_tx_mode(input ch_ctrl_t c);
        return tx_mode_e'({c.fifo_en, c.drain_wait});
    endfunction

    function automatic rx_mode_e pick_rx_mode(input ch_ctrl_t c);
        return rx_mode_e'(c.fifo_en);
    endfunction

    function automatic int unsigned count_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/uart_irq_trig_cmp.sv
module uart_irq_trig_cmp #(
    parameter int unsigned CW = 8
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    output logic          at_level,
    output logic          empty
);
    always_comb begin
        at_level = (count >= level);
        empty    = (count == '0);
    end
endmodule

// File: rtl/uart_irq_tx_req.sv
module uart_irq_tx_req
    import uart_irq_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  ch_ctrl_t      ctrl,
    input  tx_flags_t     flags,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    output logic          req
);
    logic     at_level;
    logic     empty;
    tx_mode_e mode;

    uart_irq_trig_cmp #(.CW(CW)) u_cmp (
        .count    (count),
        .level    (level),
        .at_level (at_level),
        .empty    (empty)
    );

    always_comb begin
        mode = pick_tx_mode(ctrl);
        unique case (mode)
            TXM_HOLD:       req = !flags.hold_full;
            TXM_HOLD_DRAIN: req = !flags.hold_full && flags.shift_idle;
            TXM_FIFO:       req = !at_level || empty;
            TXM_FIFO_DRAIN: req = !at_level || (empty && flags.shift_idle);
            default:        req = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_irq_rx_req.sv
module uart_irq_rx_req
    import uart_irq_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  ch_ctrl_t      ctrl,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] level,
    output logic          req
);
    logic     at_level;
    logic     empty;
    rx_mode_e mode;

    uart_irq_trig_cmp #(.CW(CW)) u_cmp (
        .count    (count),
        .level    (level),
        .at_level (at_level),
        .empty    (empty)
    );

    always_comb begin
        mode = pick_rx_mode(ctrl);
        unique case (mode)
            RXM_HOLD: req = !empty;
            RXM_FIFO: req = at_level && !empty;
            default:  req = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_irq_chan.sv
module uart_irq_chan
    import uart_irq_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_ctrl_t      ctrl,
    input  tx_flags_t     flags,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] tx_level,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_level,
    output logic          irq
);
    logic tx_req;
    logic rx_req;
    logic irq_d;

    uart_irq_tx_req #(.CW(CW)) u_tx (
        .ctrl  (ctrl),
        .flags (flags),
        .count (tx_count),
        .level (tx_level),
        .req   (tx_req)
    );

    uart_irq_rx_req #(.CW(CW)) u_rx (
        .ctrl  (ctrl),
        .count (rx_count),
        .level (rx_level),
        .req   (rx_req)
    );

    always_comb irq_d = (tx_req && ctrl.tx_en) || (rx_req && ctrl.rx_en);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= irq_d;
    end
endmodule

// File: rtl/uart_irq_pin.sv
module uart_irq_pin
    import uart_irq_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned CW    = count_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    fifo_en,
    input  logic [NCH-1:0]    rs485_auto,
    input  logic [NCH-1:0]    tx_ien,
    input  logic [NCH-1:0]    rx_ien,
    input  logic [NCH-1:0]    thr_full,
    input  logic [NCH-1:0]    tsr_idle,
    input  logic [NCH*CW-1:0] tx_count,
    input  logic [NCH*CW-1:0] tx_trig,
    input  logic [NCH*CW-1:0] rx_count,
    input  logic [NCH*CW-1:0] rx_trig,
    output logic [NCH-1:0]    irq
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_ctrl_t  ctrl;
        tx_flags_t flags;

        always_comb begin
            ctrl.fifo_en     = fifo_en[c];
            ctrl.drain_wait  = rs485_auto[c];
            ctrl.tx_en       = tx_ien[c];
            ctrl.rx_en       = rx_ien[c];
            flags.hold_full  = thr_full[c];
            flags.shift_idle = tsr_idle[c];
        end

        uart_irq_chan #(.CW(CW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl),
            .flags    (flags),
            .tx_count (tx_count[c*CW +: CW]),
            .tx_level (tx_trig[c*CW +: CW]),
            .rx_count (rx_count[c*CW +: CW]),
            .rx_level (rx_trig[c*CW +: CW]),
            .irq      (irq[c])
        );
    end
endmodule

// File: rtl/uart_irq_pin_chk.sv
module uart_irq_pin_chk #(
    parameter int unsigned NCH = 2,
    parameter int unsigned CW  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    fifo_en,
    input logic [NCH-1:0]    rs485_auto,
    input logic [NCH-1:0]    tx_ien,
    input logic [NCH-1:0]    rx_ien,
    input logic [NCH-1:0]    thr_full,
    input logic [NCH-1:0]    tsr_idle,
    input logic [NCH*CW-1:0] tx_count,
    input logic [NCH*CW-1:0] tx_trig,
    input logic [NCH*CW-1:0] rx_count,
    input logic [NCH*CW-1:0] rx_trig,
    input logic [NCH-1:0]    irq
);
    logic seen = 1'b0;
    always_ff @(posedge clk) seen <= 1'b1;

    // R1: output cleared one edge after reset
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        seen && $past(rst) |-> irq == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R8: both enables off keeps the line low
        a_r8_gated_off: assert property (@(posedge clk) disable iff (rst)
            seen && !$past(rst) && !$past(tx_ien[c]) && !$past(rx_ien[c]) |-> !irq[c]);

        // R2: holding-register transmit follows the full flag
        a_r2_hold_tx: assert property (@(posedge clk) disable iff (rst)
            seen && !$past(rst) && $past(tx_ien[c]) && !$past(rx_ien[c])
            && !$past(fifo_en[c]) && !$past(rs485_auto[c]) |-> irq[c] == !$past(thr_full[c]));

        // R3: drain wait blocks while the shift register is busy
        a_r3_drain_busy: assert property (@(posedge clk) disable iff (rst)
            seen && !$past(rst) && !$past(rx_ien[c]) && !$past(fifo_en[c])
            && $past(rs485_auto[c]) && !$past(tsr_idle[c]) |-> !irq[c]);

        // R6: single-byte receive follows the held byte
        a_r6_hold_rx: assert property (@(posedge clk) disable iff (rst)
            seen && !$past(rst) && !$past(tx_ien[c]) && $past(rx_ien[c]) && !$past(fifo_en[c])
            |-> irq[c] == ($past(rx_count[c*CW +: CW]) != '0));

        // R7: below the receive trigger no request
        a_r7_rx_below: assert property (@(posedge clk) disable iff (rst)
            seen && !$past(rst) && !$past(tx_ien[c]) && $past(fifo_en[c])
            && ($past(rx_count[c*CW +: CW]) < $past(rx_trig[c*CW +: CW])) |-> !irq[c]);
    end
endmodule

bind uart_irq_pin uart_irq_pin_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .rs485_auto (rs485_auto),
    .tx_ien     (tx_ien),
    .rx_ien     (rx_ien),
    .thr_full   (thr_full),
    .tsr_idle   (tsr_idle),
    .tx_count   (tx_count),
    .tx_trig    (tx_trig),
    .rx_count   (rx_count),
    .rx_trig    (rx_trig),
    .irq        (irq)
);

// File: tb/tb_uart_irq_pin.sv
`timescale 1ns/1ps
module tb_uart_irq_pin;
    localparam int NCH = 2;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst;
    logic [NCH-1:0] fifo_en, rs485_auto, tx_ien, rx_ien, thr_full, tsr_idle;
    logic [CW-1:0]  txc [NCH];
    logic [CW-1:0]  txt [NCH];
    logic [CW-1:0]  rxc [NCH];
    logic [CW-1:0]  rxt [NCH];
    logic [NCH*CW-1:0] tx_count, tx_trig, rx_count, rx_trig;
    logic [NCH-1:0] irq;

    always #5 clk = ~clk;

    assign tx_count = {txc[1], txc[0]};
    assign tx_trig  = {txt[1], txt[0]};
    assign rx_count = {rxc[1], rxc[0]};
    assign rx_trig  = {rxt[1], rxt[0]};

    uart_irq_pin #(.NCH(NCH), .DEPTH(128), .CW(CW)) dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rs485_auto(rs485_auto),
        .tx_ien(tx_ien), .rx_ien(rx_ien), .thr_full(thr_full), .tsr_idle(tsr_idle),
        .tx_count(tx_count), .tx_trig(tx_trig), .rx_count(rx_count), .rx_trig(rx_trig),
        .irq(irq)
    );

    int total = 0;
    int fails = 0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        fifo_en = '0; rs485_auto = '0; tx_ien = '0; rx_ien = '0;
        thr_full = '1; tsr_idle = '1;
        for (int c = 0; c < NCH; c++) begin
            txc[c] = '0; txt[c] = '0; rxc[c] = '0; rxt[c] = '0;
        end
    endtask

    // Vector layout: req[42:39] fe rs ti ri thr tsr txc[32:25] txt[24:17] rxc[16:9] rxt[8:1] exp[0]
    localparam int NV = 21;
    localparam logic [42:0] VECS [NV] = '{
        {4'd2, 6'b001011, 8'd0,   8'd0,  8'd0,   8'd0,   1'b0}, // R2 byte held
        {4'd2, 6'b001001, 8'd0,   8'd0,  8'd0,   8'd0,   1'b1}, // R2 empty
        {4'd3, 6'b011000, 8'd0,   8'd0,  8'd0,   8'd0,   1'b0}, // R3 shift busy
        {4'd3, 6'b011001, 8'd0,   8'd0,  8'd0,   8'd0,   1'b1}, // R3 drained
        {4'd3, 6'b011011, 8'd0,   8'd0,  8'd0,   8'd0,   1'b0}, // R3 byte held
        {4'd4, 6'b101001, 8'd10,  8'd16, 8'd0,   8'd0,   1'b1}, // R4 below
        {4'd4, 6'b101001, 8'd16,  8'd16, 8'd0,   8'd0,   1'b0}, // R4 equal
        {4'd4, 6'b101001, 8'd100, 8'd16, 8'd0,   8'd0,   1'b0}, // R4 above
        {4'd4, 6'b101000, 8'd0,   8'd0,  8'd0,   8'd0,   1'b1}, // R4 empty, trig 0
        {4'd5, 6'b111000, 8'd0,   8'd0,  8'd0,   8'd0,   1'b0}, // R5 empty, shift busy
        {4'd5, 6'b111001, 8'd0,   8'd0,  8'd0,   8'd0,   1'b1}, // R5 empty, drained
        {4'd5, 6'b111000, 8'd5,   8'd8,  8'd0,   8'd0,   1'b1}, // R5 below trig
        {4'd5, 6'b111001, 8'd8,   8'd8,  8'd0,   8'd0,   1'b0}, // R5 at trig
        {4'd6, 6'b000100, 8'd0,   8'd0,  8'd0,   8'd0,   1'b0}, // R6 nothing held
        {4'd6, 6'b000100, 8'd0,   8'd0,  8'd1,   8'd0,   1'b1}, // R6 byte held
        {4'd7, 6'b100100, 8'd0,   8'd0,  8'd31,  8'd32,  1'b0}, // R7 below
        {4'd7, 6'b100100, 8'd0,   8'd0,  8'd32,  8'd32,  1'b1}, // R7 equal
        {4'd7, 6'b100100, 8'd0,   8'd0,  8'd128, 8'd128, 1'b1}, // R7 full
        {4'd7, 6'b100100, 8'd0,   8'd0,  8'd0,   8'd0,   1'b0}, // R7 empty, trig 0
        {4'd8, 6'b000001, 8'd0,   8'd0,  8'd5,   8'd0,   1'b0}, // R8 both disabled
        {4'd8, 6'b001111, 8'd0,   8'd0,  8'd3,   8'd0,   1'b1}  // R8 rx alone sets line
    };

    initial begin
        idle_all();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R1 after reset", irq, 2'b00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            v = VECS[i];
            fifo_en[0] = v[38]; rs485_auto[0] = v[37];
            tx_ien[0] = v[36]; rx_ien[0] = v[35];
            thr_full[0] = v[34]; tsr_idle[0] = v[33];
            txc[0] = v[32:25]; txt[0] = v[24:17];
            rxc[0] = v[16:9];  rxt[0] = v[8:1];
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", v[42:39], i), irq, {1'b0, v[0]});
        end

        // R9: new value appears only after the next rising edge
        idle_all();
        @(negedge clk);
        chk("R9 idle", irq, 2'b00);
        tx_ien[0] = 1'b1; thr_full[0] = 1'b0;
        #4;
        chk("R9 held before edge", irq, 2'b00);
        @(negedge clk);
        chk("R9 after edge", irq, 2'b01);

        // R10: channel 1 alone, using its own fields
        idle_all();
        fifo_en[1] = 1'b1; rx_ien[1] = 1'b1; rxc[1] = 8'd40; rxt[1] = 8'd20;
        rxc[0] = 8'd40; rxt[0] = 8'd20;
        @(negedge clk);
        chk("R10 ch1 only", irq, 2'b10);
        fifo_en[0] = 1'b1; rx_ien[0] = 1'b1; rxc[1] = 8'd10;
        @(negedge clk);
        chk("R10 ch0 only", irq, 2'b01);

        // R1: reset overrides active requests
        tx_ien = '1; thr_full = '0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset with requests", irq, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 release resumes", irq, 2'b11);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule